// File: doc/BRIEF.md
# EEE Transmit Low Power Idle Controller

This block decides, cycle by cycle, whether the transmit path of a gigabit Ethernet MAC should hold the PHY-side encoder in Low Power Idle. Software programs a control/status word, an idle-entry count and a link-status hold-off count through a simple register port. The block watches three transmitter signals: a frame waiting to be sent, the transmitter being idle, and a request to flush the transmit FIFO. From these it drives a single LPI request toward the encoder.

There are three ways to enter LPI. In the one-shot automatic mode, LPI is entered as soon as nothing remains to send, and the enable bit clears itself when LPI ends. In the timed mode, the transmitter must have stayed idle for a programmed number of cycles, and the enable bit stays set, so every later idle stretch enters LPI again. In the software-request mode, the enable bit alone asks for LPI. Every entry is held back until the link-status bit has stayed set for the programmed hold-off time. One-cycle flags mark each entry and each exit, and sticky copies of these flags can be read back.

Top module: `eee_tx_lpi_ctrl`

## Requirements
- R1: After reset, `lpi_assert` and both event flags are 0, and selectors 0, 1 and 2 all read 0.
- R2: While control bit 16 (enable) is 0, LPI is never entered, whatever the other bits hold. If enable is cleared while LPI is active, `lpi_assert` drops on the clock edge after the edge that wrote the 0.
- R3: When enable=1, automate (bit 19)=1 and timer-enable (bit 20)=0, LPI is entered on the first edge at which no frame is pending and the transmitter is idle. It is not entered while the transmitter is busy.
- R4: In the mode of R3, a pending frame or a FIFO flush request ends LPI on the next edge, and the hardware clears the enable bit at that edge. No further entry happens until software sets enable again.
- R5: When enable, automate and timer-enable are all 1, with an idle-entry count T greater than 0, LPI is entered on the (T+1)th consecutive edge at which the transmitter is sampled idle. Any busy cycle restarts the count.
- R6: In the timed mode, an exit caused by a pending frame leaves the enable bit at 1, and the next idle period of T+1 cycles enters LPI again without a register write.
- R7: An idle-entry count of 0 prevents any entry in the timed mode.
- R8: Entry is held off until the link-status bit (bit 17) has been sampled at 1 on L consecutive edges, where L is the link-status count. Clearing the bit restarts that count and ends an active LPI on the following edge.
- R9: With enable=1 and automate=0, LPI is entered when the transmitter is idle, and timer-enable has no effect. A pending frame does not end LPI; only clearing enable or link-status ends it.
- R10: `lpi_enter` pulses for exactly one cycle, in the first cycle that `lpi_assert` is high. `lpi_exit` pulses for exactly one cycle, in the first cycle that it is low again. Control-word bits 0 (entered) and 1 (exited) hold these events until the control word is read. Bit 2 shows the live LPI state. A read clears bits 0 and 1.
- R11: Selector 0 is the control/status word, selector 1 the idle-entry count (low IDLE_W bits), and selector 2 the link-status count (low LINK_W bits). Bits that are not implemented read as 0, and the status bits cannot be written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_rd | input | 1 | Read strobe; a read of selector 0 clears the sticky flags |
| reg_sel | input | 2 | Register selector: 0 control/status, 1 idle count, 2 link count |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the current selector (combinational) |
| frame_pending | input | 1 | A frame is waiting to be transmitted |
| tx_idle | input | 1 | The transmitter has nothing in flight |
| fifo_flush | input | 1 | Transmit FIFO flush request |
| lpi_assert | output | 1 | LPI request toward the PHY-side encoder |
| lpi_enter | output | 1 | One-cycle flag on LPI entry |
| lpi_exit | output | 1 | One-cycle flag on LPI exit |

## Verification
The hardest case to reach is the difference between the two automatic modes after an exit. A single frame has to end LPI, and then the bench has to observe whether the enable bit survived. The bench first runs a one-shot entry and exit and reads the control word back to confirm that enable was cleared. It then runs a timed entry that is broken by a busy cycle partway through the idle count, so the restart rule is exercised, and lets a second idle stretch re-enter LPI with no register write in between. The link hold-off restart is reached the same way: the link-status bit is dropped partway through the count and raised again, and the entry cycle is checked against the full count.

// File: rtl/eee_tx_lpi_ctrl.sv
module eee_tx_lpi_ctrl #(
  parameter int IDLE_W = 16,
  parameter int LINK_W = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        frame_pending,
  input  logic        tx_idle,
  input  logic        fifo_flush,
  output logic        lpi_assert,
  output logic        lpi_enter,
  output logic        lpi_exit
);
  localparam int B_EN  = 16;
  localparam int B_PLS = 17;
  localparam int B_AUT = 19;
  localparam int B_TE  = 20;

  logic en_q, pls_q, aut_q, te_q, lpi_q, st_in_q, st_out_q, enp_q, exp_q;
  logic [IDLE_W-1:0] idle_tmr_q, idle_cnt_q;
  logic [LINK_W-1:0] link_tmr_q, link_cnt_q;

  wire wr_ctl  = reg_wr && reg_sel == 2'd0;
  wire rd_ctl  = reg_rd && reg_sel == 2'd0;
  wire busy    = frame_pending || !tx_idle;
  wire link_ok = pls_q && link_cnt_q >= link_tmr_q;
  wire mode_auto  = en_q && aut_q && !te_q;
  wire mode_timer = en_q && aut_q && te_q;
  wire timer_hit  = idle_tmr_q != '0 && idle_cnt_q >= idle_tmr_q;
  wire go_in  = !lpi_q && en_q && link_ok && !busy && !fifo_flush &&
                (!mode_timer || timer_hit);
  wire go_out = lpi_q && (!en_q || !pls_q || (aut_q && (frame_pending || fifo_flush)));
  wire unused_wdata = ^reg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, pls_q, aut_q, te_q} <= '0;
      idle_tmr_q <= '0;
      link_tmr_q <= '0;
    end else begin
      if (wr_ctl) begin
        en_q  <= reg_wdata[B_EN];
        pls_q <= reg_wdata[B_PLS];
        aut_q <= reg_wdata[B_AUT];
        te_q  <= reg_wdata[B_TE];
      end else if (go_out && mode_auto) begin
        en_q <= 1'b0;
      end
      if (reg_wr && reg_sel == 2'd1) idle_tmr_q <= reg_wdata[IDLE_W-1:0];
      if (reg_wr && reg_sel == 2'd2) link_tmr_q <= reg_wdata[LINK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt_q <= '0;
      link_cnt_q <= '0;
    end else begin
      if (busy) idle_cnt_q <= '0;
      else if (idle_cnt_q != '1) idle_cnt_q <= idle_cnt_q + 1'b1;
      if (!pls_q) link_cnt_q <= '0;
      else if (link_cnt_q != '1) link_cnt_q <= link_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {lpi_q, enp_q, exp_q, st_in_q, st_out_q} <= '0;
    end else begin
      if (go_in) lpi_q <= 1'b1;
      else if (go_out) lpi_q <= 1'b0;
      enp_q <= go_in;
      exp_q <= go_out;
      st_in_q  <= rd_ctl ? go_in  : (st_in_q  || go_in);
      st_out_q <= rd_ctl ? go_out : (st_out_q || go_out);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      2'd0: begin
        reg_rdata[B_EN]  = en_q;
        reg_rdata[B_PLS] = pls_q;
        reg_rdata[B_AUT] = aut_q;
        reg_rdata[B_TE]  = te_q;
        reg_rdata[2:0]   = {lpi_q, st_out_q, st_in_q};
      end
      2'd1: reg_rdata[IDLE_W-1:0] = idle_tmr_q;
      2'd2: reg_rdata[LINK_W-1:0] = link_tmr_q;
      default: reg_rdata = '0;
    endcase
  end

  assign lpi_assert = lpi_q;
  assign lpi_enter  = enp_q;
  assign lpi_exit   = exp_q;

  p_no_entry_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !lpi_q) |=> !lpi_q);
  p_leave_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (lpi_q && !en_q) |=> !lpi_q);
  p_oneshot_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lpi_q) && $past(mode_auto) && !$past(wr_ctl)) |-> !en_q);
  p_timer_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lpi_q) && $past(mode_timer) && !$past(wr_ctl)) |-> en_q);
  p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_q) |-> $past(pls_q));
  p_enter_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lpi_q) |-> enp_q);
  p_exit_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exp_q |-> (!lpi_q && $past(lpi_q)));
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({enp_q, exp_q}));
endmodule

// File: tb/eee_tx_lpi_ctrl_test.sv
module eee_tx_lpi_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic frame_pending = 0, tx_idle = 1, fifo_flush = 0;
  logic lpi_assert, lpi_enter, lpi_exit;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] q_exp[$];
  string q_tag[$];

  localparam logic [31:0] EN = 32'h1 << 16, PLS = 32'h1 << 17,
                          AUT = 32'h1 << 19, TE = 32'h1 << 20;

  eee_tx_lpi_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frame_pending(frame_pending), .tx_idle(tx_idle), .fifo_flush(fifo_flush),
    .lpi_assert(lpi_assert), .lpi_enter(lpi_enter), .lpi_exit(lpi_exit)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [2:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      checks++;
      if ({lpi_assert, lpi_enter, lpi_exit} !== e) begin
        fails++;
        $display("FAIL %s: lpi/enter/exit = %b expected %b at %0t", t,
                 {lpi_assert, lpi_enter, lpi_exit}, e, $time);
      end
    end
  end

  task automatic step(input logic l, input logic n, input logic x, input string t);
    @(posedge clk);
    #1;
    q_exp.push_back({l, n, x});
    q_tag.push_back(t);
  endtask

  task automatic nstep(input int k, input logic l, input string t);
    for (int i = 0; i < k; i++) step(l, 1'b0, 1'b0, t);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d, input logic l,
                    input logic n, input logic x, input string t);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    step(l, n, x, t);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [31:0] d, input logic l,
                    input string t);
    reg_sel = s; reg_rd = 1;
    #1;
    checks++;
    if (reg_rdata !== d) begin
      fails++;
      $display("FAIL %s: sel %0d read %h expected %h", t, s, reg_rdata, d);
    end
    step(l, 1'b0, 1'b0, t);
    reg_rd = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd(0, 0, 0, "R1"); rd(1, 0, 0, "R1"); rd(2, 0, 0, "R1");
    // R11 register map
    wr(1, 32'h0000_0003, 0, 0, 0, "R11");
    wr(2, 32'h0000_0002, 0, 0, 0, "R11");
    rd(1, 3, 0, "R11"); rd(2, 2, 0, "R11");
    wr(1, 32'hFFFF_0005, 0, 0, 0, "R11");
    rd(1, 5, 0, "R11");
    wr(2, 0, 0, 0, 0, "R11");
    wr(1, 3, 0, 0, 0, "R11");
    wr(0, PLS | AUT | TE | 32'h7, 0, 0, 0, "R11");
    rd(0, PLS | AUT | TE, 0, "R11");
    // R2 enable low: no entry
    nstep(10, 0, "R2");
    // R3 one-shot entry waits for idle
    tx_idle = 0;
    wr(0, EN | PLS | AUT, 0, 0, 0, "R3");
    nstep(5, 0, "R3");
    tx_idle = 1;
    step(1, 1, 0, "R3");
    nstep(3, 1, "R3");
    rd(0, EN | PLS | AUT | 32'h5, 1, "R10");
    rd(0, EN | PLS | AUT | 32'h4, 1, "R10");
    // R4 exit on frame, enable cleared
    frame_pending = 1;
    step(0, 0, 1, "R4");
    frame_pending = 0;
    rd(0, PLS | AUT | 32'h2, 0, "R4");
    nstep(5, 0, "R4");
    // R4 exit on flush
    wr(0, EN | PLS | AUT, 0, 0, 0, "R4");
    step(1, 1, 0, "R4");
    fifo_flush = 1;
    step(0, 0, 1, "R4");
    fifo_flush = 0;
    rd(0, PLS | AUT | 32'h3, 0, "R4");
    // R5 timed entry after T+1 idle edges, T=3
    tx_idle = 0;
    wr(0, EN | PLS | AUT | TE, 0, 0, 0, "R5");
    nstep(2, 0, "R5");
    tx_idle = 1;
    nstep(3, 0, "R5");
    step(1, 1, 0, "R5");
    // R6 exit keeps enable; restart then re-entry
    frame_pending = 1;
    step(0, 0, 1, "R6");
    frame_pending = 0;
    nstep(2, 0, "R5");
    tx_idle = 0;
    step(0, 0, 0, "R5");
    tx_idle = 1;
    nstep(3, 0, "R5");
    step(1, 1, 0, "R6");
    rd(0, EN | PLS | AUT | TE | 32'h7, 1, "R6");
    // R2 clearing enable exits on the following edge
    wr(0, PLS | AUT | TE, 1, 0, 0, "R2");
    step(0, 0, 1, "R2");
    // R7 zero idle count blocks timed entry
    wr(1, 0, 0, 0, 0, "R7");
    wr(0, EN | PLS | AUT | TE, 0, 0, 0, "R7");
    nstep(20, 0, "R7");
    // R8 link hold-off L=4
    wr(2, 4, 0, 0, 0, "R8");
    wr(0, 0, 0, 0, 0, "R8");
    wr(0, EN | PLS | AUT, 0, 0, 0, "R8");
    nstep(4, 0, "R8");
    step(1, 1, 0, "R8");
    wr(0, EN | AUT, 1, 0, 0, "R8");
    step(0, 0, 1, "R8");
    // R9 software-request mode
    wr(0, PLS, 0, 0, 0, "R9");
    tx_idle = 0;
    wr(0, EN | PLS | TE, 0, 0, 0, "R9");
    nstep(3, 0, "R9");
    tx_idle = 1;
    step(1, 1, 0, "R9");
    frame_pending = 1;
    nstep(3, 1, "R9");
    frame_pending = 0;
    wr(0, PLS | TE, 1, 0, 0, "R9");
    step(0, 0, 1, "R9");
    // R8 hold-off restart when link bit drops mid-count
    wr(0, EN, 0, 0, 0, "R8");
    wr(0, EN | PLS, 0, 0, 0, "R8");
    nstep(2, 0, "R8");
    wr(0, EN, 0, 0, 0, "R8");
    wr(0, EN | PLS, 0, 0, 0, "R8");
    nstep(4, 0, "R8");
    step(1, 1, 0, "R8");
    wr(0, EN, 1, 0, 0, "R8");
    step(0, 0, 1, "R8");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule